// File: doc/BRIEF.md
# Configurable interrupt trigger detector

This block holds one request flag per interrupt source and decides, on every system clock edge, whether each flag sets, holds or clears. Each source has a two-bit sense mode: level, falling edge, rising edge or both edges. The block registers the previous level of every input, so edges are found by comparing the current input with the value sampled at the previous edge. Level sources follow their input. Edge sources latch until the source is acknowledged or software clears them.

Software uses a byte-wide register port with two windows. The flag window gives one byte per source: it reads the flag and can clear an edge flag. The pin window gives one byte per external pin and holds that pin's sense mode. External pins map onto a contiguous range of sources that starts at a parameterised base. When a level source that is currently presented to the processor drops, the block pulses a per-source withdraw output. This tells the downstream arbiter to take the request back.

Top module: `irq_sense_bank`

## Requirements
- R1: Sense codes are 0 level, 1 falling edge, 2 rising edge and 3 both edges. Port address bit AW-1 selects the window: 1 is the pin window, 0 is the flag window. A write to pin-window byte k stores data bits [3:2] as the mode of source PIN_BASE+k, where PIN_BASE is clamped to NSRC. Only pins k < NPIN whose source index is below NSRC are mapped.
- R2: A level-mode source's pending bit equals its input as sampled at the previous clock edge.
- R3: An edge-mode flag sets when the input at an edge differs from the previous sample in the selected direction. Falling is 1 then 0, rising is 0 then 1, and both edges is any change. The previous sample resets to 0.
- R4: An edge-mode flag holds until a clear. A clear is a flag-window write whose data bit 0 is 0, or an acknowledge. An edge seen in the same cycle as a clear wins, and the flag stays set.
- R5: For level-mode sources, flag writes and acknowledges have no effect. A flag write with data bit 0 set never sets any flag.
- R6: When a level-mode source has its flag set, its input is sampled low, and it is the presented source (cur_valid with cur_idx equal to it), withdraw for that source is high for the next cycle only. In that same cycle its pending bit is already low. At most one withdraw bit is high at a time.
- R7: At reset all pending and withdraw bits are 0. Sources whose bit is set in LEVEL_MASK start in level mode, and all other sources start in rising-edge mode.
- R8: Reads are combinational. A flag-window read returns the flag in bit 0 and zeros elsewhere. A pin-window read returns the mode in bits [3:2] and zeros elsewhere. An unmapped pin reads 0, and writes to it change nothing.
- R9: With ack_valid high, the edge-mode flag of source ack_idx clears at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Raw source inputs |
| reg_addr | input | AW | Register address; bit AW-1 selects the pin window |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | IW | Acknowledged source |
| cur_valid | input | 1 | A request is presented to the processor |
| cur_idx | input | IW | Index of the presented source |
| pending | output | NSRC | Request flags |
| withdraw | output | NSRC | One-cycle withdraw pulses |

## Verification
Pending bits, withdraw pulses and mode updates all change one clock edge after the inputs that cause them. Read data is combinational, taken from the current address and the state left by the last edge. The bench drives every input on the falling edge and computes the next model state at once. It then compares pending, withdraw and read data at the following falling edge, so each result is checked half a cycle after it becomes due. Directed checks on acknowledge, write and edge collisions use the same single-edge timing.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'd0,
    SENSE_FALL  = 2'd1,
    SENSE_RISE  = 2'd2,
    SENSE_BOTH  = 2'd3
  } sense_e;

  // Edge qualifier: does the change from prev to now match the mode?
  function automatic logic edge_hit(sense_e m, logic prev, logic now);
    case (m)
      SENSE_FALL: return prev & ~now;
      SENSE_RISE: return ~prev & now;
      SENSE_BOTH: return prev ^ now;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic int clamp_base(int base, int nsrc);
    return (base > nsrc) ? nsrc : base;
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_sense_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_raw,
  input  logic       in_now,
  input  logic       sw_clr,
  input  logic       ack_clr,
  input  logic       presented,
  output logic       flag,
  output logic       withdraw
);

  sense_e mode;
  logic   prev;
  logic   hit;
  logic   is_level;
  logic   any_clr;

  assign mode     = sense_e'(mode_raw);
  assign is_level = (mode == SENSE_LEVEL);
  assign hit      = edge_hit(mode, prev, in_now);
  assign any_clr  = sw_clr | ack_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= 1'b0;
      flag     <= 1'b0;
      withdraw <= 1'b0;
    end else begin
      prev     <= in_now;
      withdraw <= is_level & flag & ~in_now & presented;
      if (is_level)     flag <= in_now;
      else if (hit)     flag <= 1'b1;
      else if (any_clr) flag <= 1'b0;
    end
  end

  // R2: level flag follows the sampled input
  assert_level_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_level |=> (flag == $past(in_now)));

  // R3/R4: a qualifying edge always leaves the flag set, even with a clear
  assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && hit) |=> flag);

  // R5: without an edge an edge-mode flag cannot rise
  assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && !hit && !flag) |=> !flag);

  // R6: a withdraw pulse comes with the flag already cleared
  assert_withdraw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    withdraw |-> !flag);

endmodule

// File: rtl/irq_mode_regs.sv
module irq_mode_regs
  import irq_sense_pkg::*;
#(
  parameter int              NSRC       = 32,
  parameter int              PIN_BASE   = 64,
  parameter int              NPIN       = 16,
  parameter logic [NSRC-1:0] LEVEL_MASK = '0,
  parameter int              IW         = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_pin,
  input  logic [1:0]           wr_mode,
  output logic [NSRC-1:0][1:0] mode
);

  localparam int PB = clamp_base(PIN_BASE, NSRC);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [1:0] RST_MODE = LEVEL_MASK[i] ? SENSE_LEVEL : SENSE_RISE;
    if ((i >= PB) && (i < PB + NPIN)) begin : g_pin
      logic [1:0] mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 mode_q <= RST_MODE;
        else if (wr_en && wr_pin == IW'(i - PB))    mode_q <= wr_mode;
      end
      assign mode[i] = mode_q;
    end else begin : g_fixed
      assign mode[i] = RST_MODE;
    end
  end

endmodule

// File: rtl/irq_sense_bank.sv
module irq_sense_bank
  import irq_sense_pkg::*;
#(
  parameter int              NSRC       = 32,
  parameter int              PIN_BASE   = 64,
  parameter int              NPIN       = 16,
  parameter logic [NSRC-1:0] LEVEL_MASK = '0,
  localparam int             IW         = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int             AW         = IW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_we,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            ack_valid,
  input  logic [IW-1:0]   ack_idx,
  input  logic            cur_valid,
  input  logic [IW-1:0]   cur_idx,
  output logic [NSRC-1:0] pending,
  output logic [NSRC-1:0] withdraw
);

  localparam int PB = clamp_base(PIN_BASE, NSRC);

  logic                 pin_win;
  logic [IW-1:0]        reg_idx;
  logic                 flag_wr_zero;
  logic [NSRC-1:0][1:0] mode;

  assign pin_win      = reg_addr[AW-1];
  assign reg_idx      = reg_addr[IW-1:0];
  assign flag_wr_zero = reg_we & ~pin_win & ~reg_wdata[0];

  irq_mode_regs #(
    .NSRC(NSRC), .PIN_BASE(PIN_BASE), .NPIN(NPIN),
    .LEVEL_MASK(LEVEL_MASK), .IW(IW)
  ) u_modes (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_we & pin_win),
    .wr_pin (reg_idx),
    .wr_mode(reg_wdata[3:2]),
    .mode   (mode)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_cell
    irq_src_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_raw (mode[i]),
      .in_now   (irq_in[i]),
      .sw_clr   (flag_wr_zero & (reg_idx == IW'(i))),
      .ack_clr  (ack_valid & (ack_idx == IW'(i))),
      .presented(cur_valid & (cur_idx == IW'(i))),
      .flag     (pending[i]),
      .withdraw (withdraw[i])
    );
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NSRC; i++) begin
      if (!pin_win && reg_idx == IW'(i))
        reg_rdata[0] = pending[i];
      if (pin_win && i >= PB && i < PB + NPIN && reg_idx == IW'(i - PB))
        reg_rdata[3:2] = mode[i];
    end
  end

  // R6: only the single presented source can be withdrawn
  assert_one_withdraw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(withdraw));

  // R8: unused read bits stay zero
  assert_rdata_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7:4] == 4'h0) && (reg_rdata[1] == 1'b0));

endmodule

// File: tb/irq_sense_bank_test.sv
`timescale 1ns/1ps
module irq_sense_bank_test;

  localparam int NSRC = 32;
  localparam int PB   = 16;
  localparam int NPIN = 16;
  localparam int IW   = 5;
  localparam int AW   = 6;
  localparam logic [NSRC-1:0] LMASK = 32'h0002_00F0;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_in = '0;
  logic [AW-1:0]   reg_addr = '0;
  logic            reg_we = 1'b0;
  logic [7:0]      reg_wdata = '0;
  logic [7:0]      reg_rdata;
  logic            ack_valid = 1'b0;
  logic [IW-1:0]   ack_idx = '0;
  logic            cur_valid = 1'b0;
  logic [IW-1:0]   cur_idx = '0;
  logic [NSRC-1:0] pending;
  logic [NSRC-1:0] withdraw;

  always #2 clk = ~clk;

  irq_sense_bank #(.NSRC(NSRC), .PIN_BASE(PB), .NPIN(NPIN), .LEVEL_MASK(LMASK)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .cur_valid(cur_valid), .cur_idx(cur_idx), .pending(pending), .withdraw(withdraw));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0]      m_mode [NSRC];
  logic [NSRC-1:0] m_prev, m_flag, m_wd;

  function automatic logic m_edge(logic [1:0] md, logic p, logic n);
    if (md == 2'd0) return 1'b0;
    if (p == n)     return 1'b0;
    return (md == 2'd3) || (md == 2'd2 && n) || (md == 2'd1 && !n);
  endfunction

  function automatic logic [7:0] m_read(logic [AW-1:0] a);
    int k;
    k = int'(a[IW-1:0]);
    if (!a[AW-1]) return {7'b0, m_flag[k]};
    if (k < NPIN && PB + k < NSRC) return {4'b0, m_mode[PB+k], 2'b00};
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NSRC; i++) m_mode[i] = LMASK[i] ? 2'd0 : 2'd2;
    m_prev = '0; m_flag = '0; m_wd = '0;
  endtask

  task automatic model_step();
    logic [NSRC-1:0] nf, nw;
    for (int i = 0; i < NSRC; i++) begin
      logic clr;
      clr = (reg_we && !reg_addr[AW-1] && int'(reg_addr[IW-1:0]) == i && !reg_wdata[0])
         || (ack_valid && int'(ack_idx) == i);
      if (m_mode[i] == 2'd0) begin
        nf[i] = irq_in[i];
        nw[i] = m_flag[i] && !irq_in[i] && cur_valid && int'(cur_idx) == i;
      end else begin
        nw[i] = 1'b0;
        if (m_edge(m_mode[i], m_prev[i], irq_in[i])) nf[i] = 1'b1;
        else if (clr)                                nf[i] = 1'b0;
        else                                         nf[i] = m_flag[i];
      end
    end
    if (reg_we && reg_addr[AW-1] && int'(reg_addr[IW-1:0]) < NPIN
        && PB + int'(reg_addr[IW-1:0]) < NSRC)
      m_mode[PB + int'(reg_addr[IW-1:0])] = reg_wdata[3:2];
    m_prev = irq_in; m_flag = nf; m_wd = nw;
  endtask

  task automatic compare_all();
    chk(pending == m_flag, "R2 R3 R4 pending", int'(pending), int'(m_flag));
    chk(withdraw == m_wd, "R6 withdraw", int'(withdraw), int'(m_wd));
    chk(reg_rdata == m_read(reg_addr), "R8 rdata", int'(reg_rdata), int'(m_read(reg_addr)));
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    reg_we = 1'b0; ack_valid = 1'b0; cur_valid = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; #0.5;
    chk(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
  endtask

  initial begin
    void'($urandom(32'd20251));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pending == '0 && withdraw == '0, "R7 reset outputs", int'(pending), 0);
    peek({1'b1, 5'd0}, 8'h08, "R7 pin0 resets rising");
    peek({1'b1, 5'd1}, 8'h00, "R7 pin1 resets level");
    peek({1'b0, 5'd0}, 8'h00, "R8 flag read after reset");

    // R3 rising edge on source 0, R4 hold, R5 write-one ignored, R4 write-zero clear
    reg_addr = {1'b0, 5'd0};
    irq_in[0] = 1'b1; tick();
    chk(pending[0], "R3 rising sets", pending[0], 1);
    irq_in[0] = 1'b0; tick();
    chk(pending[0], "R4 hold after drop", pending[0], 1);
    reg_we = 1'b1; reg_wdata = 8'h01; tick(); idle();
    chk(pending[0], "R5 write one no change", pending[0], 1);
    reg_we = 1'b1; reg_wdata = 8'hFE; tick(); idle();
    chk(!pending[0], "R4 write zero clears", pending[0], 0);

    // R1 falling mode on pin 0 -> source 16
    reg_addr = {1'b1, 5'd0}; reg_we = 1'b1; reg_wdata = 8'hF4; tick(); idle();
    peek({1'b1, 5'd0}, 8'h04, "R1 pin mode readback");
    irq_in[16] = 1'b1; tick();
    chk(!pending[16], "R1 falling ignores rise", pending[16], 0);
    irq_in[16] = 1'b0; ack_valid = 1'b1; ack_idx = 5'd16; tick(); idle();
    chk(pending[16], "R4 edge wins over ack", pending[16], 1);
    ack_valid = 1'b1; ack_idx = 5'd16; tick(); idle();
    chk(!pending[16], "R9 ack clears edge flag", pending[16], 0);

    // R5/R6 level source 4
    irq_in[4] = 1'b1; tick();
    chk(pending[4], "R2 level follows", pending[4], 1);
    reg_addr = {1'b0, 5'd4}; reg_we = 1'b1; reg_wdata = 8'h00;
    ack_valid = 1'b1; ack_idx = 5'd4; tick(); idle();
    chk(pending[4], "R5 level ignores clears", pending[4], 1);
    cur_valid = 1'b1; cur_idx = 5'd4; irq_in[4] = 1'b0; tick(); idle();
    chk(withdraw[4] && !pending[4], "R6 withdraw on drop", int'(withdraw), 16);
    tick();
    chk(withdraw == '0, "R6 single pulse", int'(withdraw), 0);

    // R8 unmapped pin
    reg_addr = {1'b1, 5'd20}; reg_we = 1'b1; reg_wdata = 8'h0C; tick(); idle();
    peek({1'b1, 5'd20}, 8'h00, "R8 unmapped pin reads zero");

    // R1 both-edge mode on pin 2 -> source 18
    reg_addr = {1'b1, 5'd2}; reg_we = 1'b1; reg_wdata = 8'h0C; tick(); idle();
    irq_in[18] = 1'b1; tick();
    chk(pending[18], "R1 both edges rise", pending[18], 1);
    ack_valid = 1'b1; ack_idx = 5'd18; tick(); idle();
    irq_in[18] = 1'b0; tick();
    chk(pending[18], "R1 both edges fall", pending[18], 1);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      irq_in = irq_in ^ ($urandom & $urandom & $urandom);
      reg_we = (r[3:0] < 4'd3);
      reg_addr = AW'($urandom);
      reg_wdata = 8'($urandom);
      ack_valid = r[4] & r[5];
      ack_idx = IW'($urandom);
      cur_valid = r[6];
      cur_idx = r[7] ? IW'(4 + r[9:8]) : 5'd17;
      tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule